// File: doc/BRIEF.md
# Wormhole Switch Output Port

This block is one output port of a wormhole-routed on-chip switch. A switch instantiates it once per output link, and every switch input is wired to every copy. Each cycle the port looks at the flits offered by all inputs, keeps only packets whose current hop direction names this port, and hands the link to one packet at a time. Arbitration happens only at packet boundaries: an input that wins keeps the port until its last flit is stored, and any other input that tries to start a packet here meanwhile is refused with a NACK so the upstream side can resend later. Nothing is stalled.

An accepted flit is written into one of several virtual-channel queues. A head flit picks the queue with the most free entries, and the rest of its packet follows it into the same queue. Every offered flit that belongs to this port gets exactly one answer, ACK if it was stored and NACK if it was not. Before storing, the head flit has its own direction code stripped from the path field, so the next switch finds its code in the lowest bits. The queues share one physical link: each cycle at most one flit leaves, chosen round-robin among the queues that hold a flit and still have downstream credit. The downstream switch returns credits one per pulse per virtual channel.

The control is a two-state machine. **Idle**: no packet owns the port. **Locked**: a packet is in progress and only its input may write. Transitions: *Idle → Locked* when a head flit (not single-flit) is accepted; *Locked → Idle* when the owner's last flit is accepted; *Idle → Idle* on no request, a NACKed head, or an accepted single-flit packet; *Locked → Locked* otherwise.

Top module: `swport_out`

## Requirements
- R1: After reset no flit is output, no ACK or NACK is raised, every queue is empty, every virtual channel holds CREDITS credits, the input pointer favours input 0 and the link pointer favours channel 0.
- R2: A flit is `{type[1:0], payload[PAY_W-1:0]}` with type 00 head, 01 body, 10 tail, 11 single-flit packet. Only a head or single flit whose payload bits [DIR_W-1:0] equal PORT_ID can start a packet here; any other flit offered while the port is Idle gets neither ACK nor NACK.
- R3: When several inputs offer a matching head in Idle, the grant goes to the first requesting input after the input that last started a packet, wrapping around.
- R4: Every matching head that loses arbitration, or arrives while another input owns the port, is NACKed.
- R5: After a head (type 00) is accepted, only that input's flits are taken until its tail (type 10) is accepted; then the port returns to Idle. A single flit (type 11) leaves the port Idle.
- R6: A flit from the granted input is ACKed if its queue had a free entry and NACKed otherwise; ACK and NACK never rise together for one input.
- R7: A head goes to the virtual channel with the most free entries, the lowest index on a tie; body and tail flits go to the channel their head used.
- R8: A stored head has its payload shifted right by DIR_W bits with zeros filled at the top; body and tail payloads are stored unchanged.
- R9: A channel sends only while its credit count is non-zero; each send takes one credit and each `credit_ret` pulse gives one back.
- R10: At most one flit leaves per cycle, chosen round-robin among channels holding a flit and credit, starting after the channel that sent last.
- R11: ACK and NACK appear one cycle after the flit is offered; a stored flit appears on the link no earlier than two cycles after it was offered; each channel keeps its flits in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | N_IN | A flit is offered on each input |
| in_flits | input | N_IN*(PAY_W+2) | Offered flits, input i at bits [i*(PAY_W+2) +: PAY_W+2] |
| in_ack | output | N_IN | Per input, flit of the previous cycle was stored |
| in_nack | output | N_IN | Per input, flit of the previous cycle was refused |
| out_valid | output | 1 | A flit is on the physical link |
| out_flit | output | PAY_W+2 | Flit on the link |
| out_vc | output | max(1,clog2(N_VC)) | Virtual channel of the flit on the link |
| credit_ret | input | N_VC | One credit returned per set bit |

## Verification
The bench goes after the packet boundary: a wrong design would re-arbitrate mid-packet, ACK an intruding head, or forget to release the port after the tail so that the next packet hangs. It checks that the round-robin pointer moves only when a packet is really started, which a design that advanced it on every request would violate. It drives a body flit into a queue that has become fuller than its neighbour, which catches a design that re-chooses the channel per flit, and fills both queues until a head must be NACKed. Finally it exhausts credits on one channel while the other keeps flowing, then restores them and checks the alternating link order, which catches sending without credit or a link multiplexer that starves one channel.

// File: rtl/swp_pkg.sv
package swp_pkg;

    typedef enum logic [1:0] {
        FT_HEAD = 2'b00,
        FT_BODY = 2'b01,
        FT_TAIL = 2'b10,
        FT_SOLO = 2'b11
    } ftype_e;

    typedef enum logic {
        PS_IDLE   = 1'b0,
        PS_LOCKED = 1'b1
    } pstate_e;

    function automatic logic opens_packet(input ftype_e f);
        return (f == FT_HEAD) || (f == FT_SOLO);
    endfunction

    function automatic logic closes_packet(input ftype_e f);
        return (f == FT_TAIL) || (f == FT_SOLO);
    endfunction

endpackage

// File: rtl/swp_match.sv
module swp_match
    import swp_pkg::*;
#(
    parameter int DIR_W   = 2,
    parameter int PORT_ID = 1
) (
    input  logic             vld,
    input  logic [1:0]       ftype,
    input  logic [DIR_W-1:0] dir,
    output logic             head_hit,
    output logic             is_last
);
    ftype_e ft;

    always_comb begin
        ft       = ftype_e'(ftype);
        // head or single flit whose leading direction code selects this port
        head_hit = vld && opens_packet(ft) && (dir == DIR_W'(PORT_ID));
        is_last  = closes_packet(ft);
    end
endmodule

// File: rtl/swp_rr_pick.sv
module swp_rr_pick #(
    parameter int N  = 4,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    input  logic [IW-1:0] last,
    output logic [N-1:0]  gnt_oh,
    output logic [IW-1:0] gnt_idx,
    output logic          any
);
    always_comb begin
        gnt_oh  = '0;
        gnt_idx = '0;
        any     = 1'b0;
        for (int i = 1; i <= N; i++) begin
            logic [IW-1:0] k;
            k = IW'((int'(last) + i) % N);
            if (!any && req[k]) begin
                any        = 1'b1;
                gnt_oh[k]  = 1'b1;
                gnt_idx    = k;
            end
        end
    end
endmodule

// File: rtl/swp_vc_fifo.sv
module swp_vc_fifo #(
    parameter int W     = 18,
    parameter int DEPTH = 4,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [W-1:0]  din,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] cnt
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_q, rd_q;
    logic [CW-1:0] cnt_q;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) mem[wr_q] <= din;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) wr_q <= bump(wr_q);
            if (pop)  rd_q <= bump(rd_q);
            unique case ({push, pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign dout = mem[rd_q];
    assign cnt  = cnt_q;

    // R6: a write is only issued when the queue has room
    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (cnt_q < CW'(DEPTH)));
    // R10: the link stage only drains a queue that holds a flit
    assert_no_underflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (cnt_q != '0));
endmodule

// File: rtl/swport_out.sv
module swport_out
    import swp_pkg::*;
#(
    parameter int N_IN     = 4,
    parameter int N_VC     = 2,
    parameter int PAY_W    = 16,
    parameter int DIR_W    = 2,
    parameter int PORT_ID  = 1,
    parameter int VC_DEPTH = 4,
    parameter int CREDITS  = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [N_IN-1:0]               in_valid,
    input  logic [N_IN*(PAY_W+2)-1:0]     in_flits,
    output logic [N_IN-1:0]               in_ack,
    output logic [N_IN-1:0]               in_nack,
    output logic                          out_valid,
    output logic [PAY_W+1:0]              out_flit,
    output logic [((N_VC>1)?$clog2(N_VC):1)-1:0] out_vc,
    input  logic [N_VC-1:0]               credit_ret
);
    localparam int FLIT_W = PAY_W + 2;
    localparam int IW     = (N_IN > 1) ? $clog2(N_IN) : 1;
    localparam int VC_W   = (N_VC > 1) ? $clog2(N_VC) : 1;
    localparam int CNT_W  = $clog2(VC_DEPTH + 1);
    localparam int CR_W   = $clog2(CREDITS + 1);

    // ---------------- stage 1: per-input decode and route match
    logic [FLIT_W-1:0] flit_a [N_IN];
    logic [N_IN-1:0]   hreq, last_a;

    for (genvar i = 0; i < N_IN; i++) begin : g_in
        assign flit_a[i] = in_flits[i*FLIT_W +: FLIT_W];
        swp_match #(.DIR_W(DIR_W), .PORT_ID(PORT_ID)) u_match (
            .vld      (in_valid[i]),
            .ftype    (flit_a[i][FLIT_W-1 -: 2]),
            .dir      (flit_a[i][DIR_W-1:0]),
            .head_hit (hreq[i]),
            .is_last  (last_a[i])
        );
    end

    // ---------------- stage 2: packet-level round-robin arbiter
    pstate_e        st_q, st_d;
    logic [IW-1:0]  own_q, own_d, rr_q, rr_d;
    logic [VC_W-1:0] ovc_q, ovc_d;
    logic [N_IN-1:0] win_oh, own_oh;
    logic [IW-1:0]  win_idx;
    logic           win_any;

    swp_rr_pick #(.N(N_IN)) u_in_arb (
        .req     (hreq),
        .last    (rr_q),
        .gnt_oh  (win_oh),
        .gnt_idx (win_idx),
        .any     (win_any)
    );

    always_comb begin
        own_oh        = '0;
        own_oh[own_q] = 1'b1;
    end

    // ---------------- queue occupancy and most-free channel choice
    logic [CNT_W-1:0] cnt_v  [N_VC];
    logic [CNT_W-1:0] free_v [N_VC];
    logic [VC_W-1:0]  best_vc;

    always_comb begin
        for (int v = 0; v < N_VC; v++) free_v[v] = CNT_W'(VC_DEPTH) - cnt_v[v];
        best_vc = '0;
        for (int v = 1; v < N_VC; v++) begin
            if (free_v[v] > free_v[best_vc]) best_vc = VC_W'(v);
        end
    end

    // ---------------- state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= PS_IDLE;
            own_q <= '0;
            ovc_q <= '0;
            rr_q  <= IW'(N_IN - 1);
        end else begin
            st_q  <= st_d;
            own_q <= own_d;
            ovc_q <= ovc_d;
            rr_q  <= rr_d;
        end
    end

    // ---------------- next state and per-input responses
    logic [N_IN-1:0] acc_vec, rej_vec;
    logic [IW-1:0]   sel_idx;
    logic [VC_W-1:0] sel_vc;
    logic            do_push;

    always_comb begin
        st_d    = st_q;
        own_d   = own_q;
        ovc_d   = ovc_q;
        rr_d    = rr_q;
        acc_vec = '0;
        rej_vec = '0;
        sel_idx = win_idx;
        sel_vc  = best_vc;
        do_push = 1'b0;
        unique case (st_q)
            PS_IDLE: begin
                rej_vec = hreq & ~win_oh;
                if (win_any) begin
                    if (free_v[best_vc] != '0) begin
                        acc_vec[win_idx] = 1'b1;
                        do_push          = 1'b1;
                        rr_d             = win_idx;
                        if (!last_a[win_idx]) begin
                            st_d  = PS_LOCKED;
                            own_d = win_idx;
                            ovc_d = best_vc;
                        end
                    end else begin
                        rej_vec[win_idx] = 1'b1;
                    end
                end
            end
            PS_LOCKED: begin
                sel_idx = own_q;
                sel_vc  = ovc_q;
                rej_vec = hreq & ~own_oh;
                if (in_valid[own_q]) begin
                    if (free_v[ovc_q] != '0) begin
                        acc_vec[own_q] = 1'b1;
                        do_push        = 1'b1;
                        if (last_a[own_q]) st_d = PS_IDLE;
                    end else begin
                        rej_vec[own_q] = 1'b1;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_ack  <= '0;
            in_nack <= '0;
        end else begin
            in_ack  <= acc_vec;
            in_nack <= rej_vec;
        end
    end

    // ---------------- stage 3: data mux and path rewrite
    logic [FLIT_W-1:0] sel_flit, wr_flit;
    ftype_e            sel_ft;

    always_comb begin
        sel_flit = flit_a[sel_idx];
        sel_ft   = ftype_e'(sel_flit[FLIT_W-1 -: 2]);
        if (opens_packet(sel_ft))
            wr_flit = {sel_flit[FLIT_W-1 -: 2], sel_flit[PAY_W-1:0] >> DIR_W};
        else
            wr_flit = sel_flit;
    end

    // ---------------- stage 4: virtual-channel queues
    logic [N_VC-1:0]   vpush, vpop;
    logic [FLIT_W-1:0] vc_dout [N_VC];

    for (genvar v = 0; v < N_VC; v++) begin : g_vc
        assign vpush[v] = do_push && (sel_vc == VC_W'(v));
        swp_vc_fifo #(.W(FLIT_W), .DEPTH(VC_DEPTH), .CW(CNT_W)) u_q (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (vpush[v]),
            .pop   (vpop[v]),
            .din   (wr_flit),
            .dout  (vc_dout[v]),
            .cnt   (cnt_v[v])
        );
    end

    // ---------------- stage 5: downstream credit counters
    logic [CR_W-1:0] cred_q [N_VC];

    always_ff @(posedge clk) begin
        for (int v = 0; v < N_VC; v++) begin
            if (!rst_n) cred_q[v] <= CR_W'(CREDITS);
            else        cred_q[v] <= cred_q[v] + CR_W'(credit_ret[v]) - CR_W'(vpop[v]);
        end
    end

    // ---------------- stage 6: link multiplexer among ready channels
    logic [N_VC-1:0] vready;
    logic [VC_W-1:0] vrr_q, vgnt_idx;
    logic            vany;

    always_comb begin
        for (int v = 0; v < N_VC; v++)
            vready[v] = (cnt_v[v] != '0) && (cred_q[v] != '0);
    end

    swp_rr_pick #(.N(N_VC)) u_vc_arb (
        .req     (vready),
        .last    (vrr_q),
        .gnt_oh  (vpop),
        .gnt_idx (vgnt_idx),
        .any     (vany)
    );

    // ---------------- stage 7: link output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_flit  <= '0;
            out_vc    <= '0;
            vrr_q     <= VC_W'(N_VC - 1);
        end else begin
            out_valid <= vany;
            if (vany) begin
                out_flit <= vc_dout[vgnt_idx];
                out_vc   <= vgnt_idx;
                vrr_q    <= vgnt_idx;
            end
        end
    end

    // ---------------- assertions
    assert_ack_nack_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ack & in_nack) == '0);
    assert_single_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(in_ack) <= 1);
    assert_locked_owner_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PS_LOCKED) |-> ((acc_vec & ~own_oh) == '0));
    assert_send_needs_credit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        vany |-> (cred_q[vgnt_idx] != '0));
    for (genvar v = 0; v < N_VC; v++) begin : g_cb
        assert_credit_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
            cred_q[v] <= CR_W'(CREDITS));
    end
endmodule

// File: tb/swport_out_tb.sv
`timescale 1ns/1ps
module swport_out_tb;
    localparam int NI = 4;
    localparam int FW = 18;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NI-1:0] in_valid = '0;
    logic [NI*FW-1:0] in_flits = '0;
    logic [NI-1:0] in_ack, in_nack;
    logic          out_valid;
    logic [FW-1:0] out_flit;
    logic [0:0]    out_vc;
    logic [1:0]    cred_auto = '0, cred_man = '0;
    logic          auto_cred = 1'b1;
    logic          done = 1'b0;
    int            total = 0, bad = 0;

    always #2.5 clk = ~clk;

    swport_out u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_flits(in_flits),
        .in_ack(in_ack), .in_nack(in_nack), .out_valid(out_valid),
        .out_flit(out_flit), .out_vc(out_vc), .credit_ret(cred_auto | cred_man)
    );

    // downstream model: return each credit one cycle after the flit is seen
    always @(negedge clk)
        cred_auto = (auto_cred && out_valid) ? (2'b01 << out_vc) : 2'b00;

    function automatic logic [FW-1:0] mkf(input logic [1:0] ft, input logic [13:0] val,
                                          input logic [1:0] dir);
        return {ft, val, dir};
    endfunction

    typedef struct packed {
        logic [3:0]    vld;
        logic [FW-1:0] f3, f2, f1, f0;
        logic [3:0]    ack, nack;
    } row_t;

    // type codes: 0 head, 1 body, 2 tail, 3 single; PORT_ID = 1
    localparam row_t TBL [9] = '{
        '{4'b0111, 18'd0, mkf(0,5,2), mkf(0,6,1), mkf(0,7,1), 4'b0001, 4'b0010}, // R3 R4
        '{4'b1011, mkf(1,8,0), 18'd0, mkf(0,6,1), mkf(1,9,0), 4'b0001, 4'b0010}, // R5
        '{4'b0011, 18'd0, 18'd0, mkf(0,6,1), mkf(2,10,0), 4'b0001, 4'b0010},     // R5
        '{4'b1011, mkf(0,11,1), 18'd0, mkf(0,6,1), mkf(3,12,1), 4'b0010, 4'b1001}, // R3 R4
        '{4'b1011, mkf(0,13,3), 18'd0, mkf(2,14,0), mkf(1,15,0), 4'b0010, 4'b0000}, // R5
        '{4'b1001, mkf(3,16,1), 18'd0, 18'd0, mkf(3,17,1), 4'b1000, 4'b0001},   // R3
        '{4'b1001, mkf(3,18,1), 18'd0, 18'd0, mkf(3,19,1), 4'b0001, 4'b1000},   // R3
        '{4'b0000, 18'd0, 18'd0, 18'd0, 18'd0, 4'b0000, 4'b0000},               // R2
        '{4'b0100, 18'd0, mkf(1,20,1), 18'd0, 18'd0, 4'b0000, 4'b0000}          // R2
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic put(input int idx, input logic [FW-1:0] f);
        in_flits[idx*FW +: FW] = f;
        in_valid[idx] = 1'b1;
    endtask

    task automatic clr();
        in_valid = '0;
        in_flits = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        idle(3);
        chk("R1 out_valid", 32'(out_valid), 0);
        chk("R1 ack", 32'(in_ack), 0);
        chk("R1 nack", 32'(in_nack), 0);
        rst_n = 1'b1;
        idle(2);

        // vector walk: arbitration, locking and route filter
        for (int i = 0; i <= 9; i++) begin
            @(negedge clk);
            if (i > 0) begin
                chk($sformatf("R3/R4/R5/R2 row %0d ack", i-1), 32'(in_ack), 32'(TBL[i-1].ack));
                chk($sformatf("R3/R4/R5/R2 row %0d nack", i-1), 32'(in_nack), 32'(TBL[i-1].nack));
            end
            clr();
            if (i < 9) begin
                in_valid = TBL[i].vld;
                in_flits = {TBL[i].f3, TBL[i].f2, TBL[i].f1, TBL[i].f0};
            end
        end
        idle(6);

        // R8 and R11: single flit, path rewrite and latency
        @(negedge clk); put(2, mkf(3, 14'h2AF1, 1));
        @(negedge clk); chk("R11 ack after one cycle", 32'(in_ack), 32'b0100); clr();
        chk("R11 not yet on link", 32'(out_valid), 0);
        @(negedge clk);
        chk("R11 link valid", 32'(out_valid), 1);
        chk("R8 head shifted", 32'(out_flit), 32'({2'b11, 16'h2AF1}));
        chk("R7 tie to vc0", 32'(out_vc), 0);
        idle(6);

        // R7 body follows head, R8 body untouched, R11 order
        @(negedge clk); put(0, mkf(0, 14'h0004, 1));
        @(negedge clk); put(0, {2'b01, 16'h1234});
        @(negedge clk); put(0, {2'b10, 16'h5678});
        chk("R8 head out", 32'(out_flit), 32'({2'b00, 16'h0004}));
        chk("R7 head vc", 32'(out_vc), 0);
        @(negedge clk); clr();
        chk("R8 body unchanged", 32'(out_flit), 32'({2'b01, 16'h1234}));
        chk("R7 body follows head vc", 32'(out_vc), 0);
        @(negedge clk);
        chk("R11 tail in order", 32'(out_flit), 32'({2'b10, 16'h5678}));
        chk("R7 tail vc", 32'(out_vc), 0);
        idle(6);
        auto_cred = 1'b0;
        idle(2);

        // R9 credit exhaustion on vc0, R7 most-free choice moves to vc1
        for (int k = 1; k <= 9; k++) begin
            @(negedge clk); put(0, mkf(3, 14'(k), 1));
            @(negedge clk); clr();
            @(negedge clk);
            if (k <= 4) begin
                chk($sformatf("R9 send with credit %0d", k), 32'(out_valid), 1);
                chk("R7 vc0 while empty", 32'(out_vc), 0);
                chk("R9 payload", 32'(out_flit[15:0]), 32'(k));
            end else if (k == 5) begin
                chk("R9 blocked without credit", 32'(out_valid), 0);
            end else begin
                chk($sformatf("R7 most free vc1 %0d", k), 32'(out_valid), 1);
                chk("R7 vc1 chosen", 32'(out_vc), 1);
                chk("R7 payload", 32'(out_flit[15:0]), 32'(k));
            end
        end

        // R6 fill both queues back to back; eighth head is refused
        @(negedge clk); put(0, mkf(3, 14'h21, 1));
        for (int k = 2; k <= 8; k++) begin
            @(negedge clk);
            chk($sformatf("R6 ack g%0d", k-1), 32'(in_ack), 32'b0001);
            clr(); put(0, mkf(3, 14'(32 + k), 1));
        end
        @(negedge clk);
        chk("R6 nack when both full", 32'(in_nack), 32'b0001);
        chk("R6 no ack when full", 32'(in_ack), 0);
        chk("R9 nothing sent at zero credit", 32'(out_valid), 0);
        clr();

        // R10 restore credits, expect alternating channels in arrival order
        begin
            int n = 0;
            for (int c = 0; c < 30; c++) begin
                @(negedge clk);
                if (out_valid) begin
                    chk($sformatf("R10 payload %0d", n), 32'(out_flit[15:0]),
                        (n == 0) ? 32'd5 : 32'(32 + n));
                    chk($sformatf("R10 vc %0d", n), 32'(out_vc), 32'(n % 2));
                    n++;
                end
                cred_man = (c < 4) ? 2'b11 : 2'b00;
            end
            chk("R10 flit count", 32'(n), 8);
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule